// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block is the per-endpoint decision logic for an interrupt or bulk USB endpoint. Firmware programs it through a small byte-wide register port: an enable bit, a two-bit handshake mode, a transaction byte count and a buffer base address. When the serial interface engine sees an IN or OUT token for this endpoint, it pulses `tok_valid`. One cycle later the responder issues a registered strobe with the handshake to send: NAK, ACK, STALL, or none when the endpoint is disabled. IN and OUT tokens get the same answer.

The ACK mode arms the endpoint for exactly one transfer. When the engine reports that a transaction completed after the responder answered ACK, the low mode bit is cleared in hardware. The endpoint then answers NAK until firmware arms it again. The byte count and the buffer base address are driven continuously to the data path. The token and completion inputs are single-cycle pulses that are always accepted, so the block applies no back-pressure and has no ready signal. The handshake strobe cannot be stalled and must be consumed in the cycle it appears.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset every register reads 0. The endpoint is disabled, the mode is NAK, `hs_valid` is 0, and `byte_count` and `fifo_base` are 0.
- R2: Registers are selected by `reg_addr`:
  - Offset 0 is control: enable in bit 7, mode in bits 6:5.
  - Offset 1 holds the byte count in its low `CNT_W` bits.
  - Offset 2 holds the buffer base address.
  - Offset 3 reads 0 and ignores writes.
  - `reg_rdata` shows the addressed register combinationally, and a write takes effect at the clock edge.
- R3: Unimplemented bits read 0 and ignore writes. These are control bits 4:0 and count bits 7:`CNT_W`.
- R4: While the endpoint is enabled, a token yields `hs_code` 1 (NAK) for mode 00, 2 (ACK) for mode 01, and 3 (STALL) for mode 10 or 11. The decision uses the mode held in the cycle of the token.
- R5: While the endpoint is disabled, a token yields `hs_valid` with `hs_code` 0 (no response). A completion pulse leaves the mode unchanged.
- R6: `hs_valid` is high for exactly the cycle after each cycle in which `tok_valid` is high, and low otherwise.
- R7: A completion pulse that arrives after an ACK handshake, with no other token in between and the endpoint enabled, clears mode bit 5 at that clock edge. The next token then gets NAK.
- R8: A completion pulse after a NAK or STALL handshake, or with no pending ACK, leaves the control register unchanged.
- R9: A firmware write to the control register in the same cycle as an auto-clear wins: the written value is stored.
- R10: `byte_count` and `fifo_base` always equal the stored count and base-address registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| tok_valid | input | 1 | Token for this endpoint seen (pulse) |
| xfer_done | input | 1 | Transaction completed (pulse) |
| hs_valid | output | 1 | Handshake decision strobe |
| hs_code | output | 2 | 0 none, 1 NAK, 2 ACK, 3 STALL |
| byte_count | output | CNT_W | Transaction byte count |
| fifo_base | output | BASE_W | Endpoint buffer base address |

## Verification
The bench builds the block with its defaults: a six-bit count, an eight-bit base address and a two-bit register offset. This makes the all-ones write patterns exercise the unused upper count bits and the unused fourth offset. A reference model predicts the handshake strobe, the pending-ACK state and every register value cycle by cycle. It runs under random mixes of writes, tokens and completions, so same-cycle collisions occur often:
- token with completion
- completion with a control write
- token with a mode change

Directed cases pin down each mode encoding, the one-shot ACK and the write-over-clear priority.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_NAK   = 2'd1,
    HS_ACK   = 2'd2,
    HS_STALL = 2'd3
  } hs_code_t;

  localparam int REG_CTRL = 0;
  localparam int REG_CNT  = 1;
  localparam int REG_BASE = 2;

  localparam int CTRL_EN_BIT = 7;
  localparam int CTRL_MODE_HI = 6;
  localparam int CTRL_MODE_LO = 5;

  function automatic hs_code_t mode_to_code(input logic en, input logic [1:0] mode);
    if (!en) return HS_NONE;
    unique case (mode)
      2'b00:   return HS_NAK;
      2'b01:   return HS_ACK;
      default: return HS_STALL;
    endcase
  endfunction
endpackage

// File: rtl/ep_regfile.sv
module ep_regfile
  import usb_ep_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int BASE_W = 8,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              clr_ack,
  output logic [7:0]        rdata,
  output logic              ep_en,
  output logic [1:0]        ep_mode,
  output logic [CNT_W-1:0]  cnt,
  output logic [BASE_W-1:0] base
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(REG_CTRL);
  localparam logic [REG_AW-1:0] A_CNT  = REG_AW'(REG_CNT);
  localparam logic [REG_AW-1:0] A_BASE = REG_AW'(REG_BASE);

  logic             en_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BASE_W-1:0] base_q;
  logic ctrl_wr, cnt_wr, base_wr;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign cnt_wr  = wr_en && (addr == A_CNT);
  assign base_wr = wr_en && (addr == A_BASE);

  // Control: a firmware write takes priority over the hardware clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 2'b00;
    end else if (ctrl_wr) begin
      en_q   <= wdata[CTRL_EN_BIT];
      mode_q <= wdata[CTRL_MODE_HI:CTRL_MODE_LO];
    end else if (clr_ack) begin
      mode_q[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      if (cnt_wr)  cnt_q  <= wdata[CNT_W-1:0];
      if (base_wr) base_q <= wdata[BASE_W-1:0];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == A_CTRL) begin
      rdata[CTRL_EN_BIT] = en_q;
      rdata[CTRL_MODE_HI:CTRL_MODE_LO] = mode_q;
    end else if (addr == A_CNT) begin
      rdata[CNT_W-1:0] = cnt_q;
    end else if (addr == A_BASE) begin
      rdata[BASE_W-1:0] = base_q;
    end
  end

  assign ep_en   = en_q;
  assign ep_mode = mode_q;
  assign cnt     = cnt_q;
  assign base    = base_q;

  // R9: a control write in the same cycle as a clear is stored as written
  p_fw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ep_en == $past(wdata[CTRL_EN_BIT]) &&
                 ep_mode == $past(wdata[CTRL_MODE_HI:CTRL_MODE_LO])));

  // R7: a clear without a competing write drops the low mode bit
  p_autoclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ack && !ctrl_wr) |=> (ep_mode[0] == 1'b0 && $stable(ep_en)));

  // R8: without write or clear the control state holds
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_ack && !ctrl_wr) |=> ($stable(ep_mode) && $stable(ep_en)));

  // R3: unimplemented control bits read as zero
  p_ctrl_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rdata[4:0] == 5'd0));
endmodule

// File: rtl/ep_hs_decider.sv
module ep_hs_decider
  import usb_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  logic       xfer_done,
  input  logic       ep_en,
  input  logic [1:0] ep_mode,
  output logic       hs_valid,
  output hs_code_t   hs_code,
  output logic       clr_ack
);
  hs_code_t next_code;
  logic     valid_q;
  hs_code_t code_q;
  logic     ack_pending_q;

  assign next_code = mode_to_code(ep_en, ep_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= HS_NONE;
    end else begin
      valid_q <= tok_valid;
      code_q  <= tok_valid ? next_code : HS_NONE;
    end
  end

  // Remember whether the most recent handshake was an ACK awaiting completion.
  always_ff @(posedge clk) begin
    if (!rst_n)         ack_pending_q <= 1'b0;
    else if (tok_valid) ack_pending_q <= (next_code == HS_ACK);
    else if (xfer_done) ack_pending_q <= 1'b0;
  end

  assign clr_ack  = xfer_done && ack_pending_q && ep_en;
  assign hs_valid = valid_q;
  assign hs_code  = code_q;

  // R6: one strobe per token, one cycle later
  p_strobe_follows_tok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> hs_valid);
  p_no_spurious_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !hs_valid);

  // R5: disabled endpoint stays silent and never auto-clears
  p_disabled_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !ep_en) |=> (hs_code == HS_NONE));
  p_no_clear_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ack |-> ep_en);

  // R4: both upper-bit modes stall
  p_stall_modes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && ep_en && ep_mode[1]) |=> (hs_code == HS_STALL));
endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
  import usb_ep_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int BASE_W = 8,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tok_valid,
  input  logic              xfer_done,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic [CNT_W-1:0]  byte_count,
  output logic [BASE_W-1:0] fifo_base
);
  logic       ep_en;
  logic [1:0] ep_mode;
  logic       clr_ack;
  hs_code_t   code;

  ep_regfile #(
    .CNT_W (CNT_W),
    .BASE_W(BASE_W),
    .REG_AW(REG_AW)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .clr_ack(clr_ack),
    .rdata  (reg_rdata),
    .ep_en  (ep_en),
    .ep_mode(ep_mode),
    .cnt    (byte_count),
    .base   (fifo_base)
  );

  ep_hs_decider u_decide (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_valid(tok_valid),
    .xfer_done(xfer_done),
    .ep_en    (ep_en),
    .ep_mode  (ep_mode),
    .hs_valid (hs_valid),
    .hs_code  (code),
    .clr_ack  (clr_ack)
  );

  assign hs_code = code;

  // R1: the strobe stays low in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !hs_valid);
endmodule

// File: tb/usb_ep_responder_tb.sv
module usb_ep_responder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       tok_valid;
  logic       xfer_done;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic [5:0] byte_count;
  logic [7:0] fifo_base;

  int checks = 0;
  int fails  = 0;

  // Reference model state
  logic [7:0] m_ctrl, m_cnt, m_base;
  logic       m_armed;

  always #5 clk = ~clk;

  usb_ep_responder u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .tok_valid(tok_valid), .xfer_done(xfer_done),
    .hs_valid(hs_valid), .hs_code(hs_code),
    .byte_count(byte_count), .fifo_base(fifo_base)
  );

  function automatic logic [1:0] code_of(input logic [7:0] c);
    if (!c[7]) return 2'd0;
    case (c[6:5])
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctrl;
      2'd1:    return m_cnt;
      2'd2:    return m_base;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at a falling edge, update the model at the rising edge,
  // and check at the following falling edge.
  task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] d,
                     input logic tk, input logic dn);
    logic [1:0] ec;
    logic       clr;
    reg_wr_en = wr; reg_addr = a; reg_wdata = d; tok_valid = tk; xfer_done = dn;
    ec  = tk ? code_of(m_ctrl) : 2'd0;
    clr = dn && m_armed && m_ctrl[7];
    @(posedge clk);
    if (tk)      m_armed = (ec == 2'd2);
    else if (dn) m_armed = 1'b0;
    if (wr && a == 2'd0)  m_ctrl = d & 8'hE0;
    else if (clr)         m_ctrl[5] = 1'b0;
    if (wr && a == 2'd1)  m_cnt  = d & 8'h3F;
    if (wr && a == 2'd2)  m_base = d;
    @(negedge clk);
    chk("R6",  int'(hs_valid), int'(tk));
    chk("R4",  int'(hs_code), int'(ec));
    chk("R2",  int'(reg_rdata), int'(model_read(a)));
    chk("R10", int'(byte_count), int'(m_cnt[5:0]));
    chk("R10", int'(fifo_base), int'(m_base));
    reg_wr_en = 1'b0; tok_valid = 1'b0; xfer_done = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    tok_valid = 1'b0; xfer_done = 1'b0;
    m_ctrl = 8'h00; m_cnt = 8'h00; m_base = 8'h00; m_armed = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1 chk("R1", int'(reg_rdata), 0);
    end
    chk("R1", int'(hs_valid), 0);
    chk("R1", int'(byte_count), 0);
    chk("R1", int'(fifo_base), 0);

    // R3: unused bits
    cyc(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0);
    chk("R3", int'(reg_rdata), 8'hE0);
    cyc(1'b1, 2'd1, 8'hFF, 1'b0, 1'b0);
    chk("R3", int'(reg_rdata), 8'h3F);
    // R2: offset 3 ignores writes and reads zero, others untouched
    cyc(1'b1, 2'd3, 8'hA5, 1'b0, 1'b0);
    chk("R2", int'(reg_rdata), 0);
    cyc(1'b1, 2'd2, 8'h5C, 1'b0, 1'b0);
    chk("R2", int'(fifo_base), 8'h5C);

    // R4: each mode encoding while enabled
    cyc(1'b1, 2'd0, 8'h80, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);  chk("R4", int'(hs_code), 1);
    cyc(1'b1, 2'd0, 8'hC0, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);  chk("R4", int'(hs_code), 3);
    cyc(1'b1, 2'd0, 8'hE0, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);  chk("R4", int'(hs_code), 3);

    // R7: ACK arms once, completion drops back to NAK
    cyc(1'b1, 2'd0, 8'hA0, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);  chk("R7", int'(hs_code), 2);
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);  chk("R7", int'(reg_rdata), 8'h80);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);  chk("R7", int'(hs_code), 1);

    // R8: completion without pending ACK
    cyc(1'b1, 2'd0, 8'hA0, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);  chk("R8", int'(reg_rdata), 8'hA0);
    cyc(1'b1, 2'd0, 8'hE0, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);  chk("R8", int'(reg_rdata), 8'hE0);

    // R9: firmware write beats auto-clear
    cyc(1'b1, 2'd0, 8'hA0, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    cyc(1'b1, 2'd0, 8'hA0, 1'b0, 1'b1);  chk("R9", int'(reg_rdata), 8'hA0);

    // R5: disabled endpoint gives no response and no clear
    cyc(1'b1, 2'd0, 8'h20, 1'b0, 1'b0);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    chk("R5", int'(hs_valid), 1);
    chk("R5", int'(hs_code), 0);
    cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);  chk("R5", int'(reg_rdata), 8'h20);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic       wr, tk, dn;
      logic [1:0] a;
      logic [7:0] d;
      wr = ($urandom % 4) == 0;
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (wr && a == 2'd0 && ($urandom % 2) == 0) d[7] = 1'b1;
      tk = ($urandom % 3) == 0;
      dn = ($urandom % 3) == 0;
      cyc(wr, a, d, tk, dn);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule